// File: doc/BRIEF.md
# Switched Datapath Tile

This block is one tile of a structured datapath built by high-level synthesis. It holds a small bank of local registers, one functional unit (FU) and a fixed number of access links to the global buses that run between tiles. Two switch groups carry all of its internal traffic. The in-switches steer either an access link or the FU result onto a register write port. The out-switches steer a register or the FU result onto an access link. The FU has no other route to the global buses: operands arrive from a local register or from an access link, and results leave through the register bank, an access link, or both in the same step.

An external controller supplies a flat control word on every clock. The word sets the FU opcode, the source of each operand, up to `NWP` register writes and a drive mask for each access link. The word is qualified by `step_valid`. The tile has no back-pressure: it accepts a valid control word on every cycle and never stalls. When `step_valid` is low, the control word is ignored for that cycle.

The FU adds, subtracts and multiplies modulo 2^`DW`, passes either operand through, and compares unsigned values. A comparison also drives the one-bit `cmp_flag` status so the controller can branch on it. If more than one source is enabled onto the same link in one step, that link reports a conflict and carries zero.

Top module: `dpt_tile`

## Requirements
- R1: After reset, every register reads 0, and with no control word applied every `link_oe`, `link_conflict` and `cmp_flag` is 0.
- R2: Operand A (and likewise B) comes from access link `opa_idx` when `opa_from_link` is 1, and from register `opa_idx` when it is 0. An index beyond the count of its kind gives 0.
- R3: Opcodes 0, 1 and 2 give a+b, a-b and a*b, each truncated to `DW` bits.
- R4: Opcodes 3, 4 and 5 compare unsigned a==b, a>b and a<b. The FU result is the outcome zero-extended to `DW` bits, and `cmp_flag` equals the outcome. `cmp_flag` is 0 for all other opcodes.
- R5: Write port p with `wr_en[p]`=1 loads register `wr_dst[p]` at the rising edge. The data is the FU result when `wr_from_fu[p]`=1 and `link_rd` of link `wr_link[p]` otherwise. The new value can be read from the next cycle on.
- R6: When several write ports target the same register in one step, the lowest-numbered port wins.
- R7: In link k's mask `drv_mask[k*(NREG+1) +: NREG+1]`, bit s < NREG selects register s and bit NREG selects the FU result. With exactly one bit set, `link_oe[k]`=1 and `link_wr` of link k carries that source in the same cycle. With no bit set, `link_oe[k]`=0 and the link value is 0.
- R8: With two or more mask bits set for link k, `link_conflict[k]`=1, `link_oe[k]`=1 and the link value is 0. Other links are not affected.
- R9: When `step_valid`=0, no register changes, and all of `link_oe`, `link_conflict` and `cmp_flag` are 0.
- R10: In one step, a single FU result can be written to a register and also driven onto a link.
- R11: Opcode 6 passes operand A and opcode 7 passes operand B unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; register writes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_valid | input | 1 | Qualifies the control word for this cycle |
| fu_op | input | 3 | FU opcode |
| opa_from_link | input | 1 | Operand A source: 1 link, 0 register |
| opa_idx | input | IW | Operand A link or register index |
| opb_from_link | input | 1 | Operand B source: 1 link, 0 register |
| opb_idx | input | IW | Operand B link or register index |
| wr_en | input | NWP | Write-port enables |
| wr_dst | input | NWP*RW | Destination register per write port |
| wr_from_fu | input | NWP | Write data source per port: 1 FU, 0 link |
| wr_link | input | NWP*LW | Link index feeding each write port |
| drv_mask | input | NLINK*(NREG+1) | Out-switch source mask per link |
| link_rd | input | NLINK*DW | Values arriving from the global buses |
| link_wr | output | NLINK*DW | Values the tile puts on the links |
| link_oe | output | NLINK | Tile drives the link this cycle |
| link_conflict | output | NLINK | More than one source enabled on the link |
| cmp_flag | output | 1 | Outcome of the current comparison |

## Verification
The FU result, the link values, `link_oe`, `link_conflict` and `cmp_flag` are combinational, so each is due in the same cycle as the control word that causes it. The bench changes inputs on the falling edge and samples 5 ns later, before the next rising edge. A register write happens at the first rising edge after its control word. The bench therefore reads the register in the following cycle, through an out-switch onto a link. Checks of R9 apply a blocked step, cross one edge, and then read back the registers it could have touched.

// File: rtl/dpt_pkg.sv
`timescale 1ns/1ps
package dpt_pkg;
  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_MUL   = 3'd2,
    OP_EQ    = 3'd3,
    OP_GT    = 3'd4,
    OP_LT    = 3'd5,
    OP_PASSA = 3'd6,
    OP_PASSB = 3'd7
  } fu_op_e;

  function automatic logic is_compare(input logic [2:0] op);
    return (op == OP_EQ) || (op == OP_GT) || (op == OP_LT);
  endfunction
endpackage

// File: rtl/dpt_opsel.sv
`timescale 1ns/1ps
// Operand source switch: picks one register or one access link.
module dpt_opsel #(
  parameter int DW    = 8,
  parameter int NREG  = 4,
  parameter int NLINK = 2,
  parameter int IW    = 2
) (
  input  logic                  from_link,
  input  logic [IW-1:0]         idx,
  input  logic [NREG*DW-1:0]    regs,
  input  logic [NLINK*DW-1:0]   links,
  output logic [DW-1:0]         val
);
  always_comb begin
    val = '0;
    if (from_link) begin
      for (int k = 0; k < NLINK; k++)
        if (int'(idx) == k) val = links[k*DW +: DW];
    end else begin
      for (int r = 0; r < NREG; r++)
        if (int'(idx) == r) val = regs[r*DW +: DW];
    end
  end
endmodule

// File: rtl/dpt_fu.sv
`timescale 1ns/1ps
// Single functional unit: arithmetic, pass-through and unsigned compare.
module dpt_fu
  import dpt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [2:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y,
  output logic          flag
);
  always_comb begin
    flag = 1'b0;
    y    = '0;
    case (fu_op_e'(op))
      OP_ADD:   y = a + b;
      OP_SUB:   y = a - b;
      OP_MUL:   y = a * b;
      OP_EQ:    flag = (a == b);
      OP_GT:    flag = (a > b);
      OP_LT:    flag = (a < b);
      OP_PASSA: y = a;
      OP_PASSB: y = b;
      default:  y = '0;
    endcase
    if (is_compare(op)) y = {{(DW-1){1'b0}}, flag};
  end
endmodule

// File: rtl/dpt_regbank.sv
`timescale 1ns/1ps
// Local register bank with in-switches on each write port.
module dpt_regbank #(
  parameter int DW    = 8,
  parameter int NREG  = 4,
  parameter int NLINK = 2,
  parameter int NWP   = 2,
  localparam int RW   = (NREG  > 1) ? $clog2(NREG)  : 1,
  localparam int LW   = (NLINK > 1) ? $clog2(NLINK) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NWP-1:0]        we,
  input  logic [NWP*RW-1:0]     dst,
  input  logic [NWP-1:0]        from_fu,
  input  logic [NWP*LW-1:0]     lsel,
  input  logic [DW-1:0]         fu_y,
  input  logic [NLINK*DW-1:0]   link_rd,
  output logic [NREG*DW-1:0]    regs
);
  logic [DW-1:0] wd [NWP];
  logic [DW-1:0] rq [NREG];
  logic [DW-1:0] nx [NREG];

  // in-switch: FU result or a link value onto each write port
  always_comb begin
    for (int p = 0; p < NWP; p++) begin
      wd[p] = '0;
      if (from_fu[p]) wd[p] = fu_y;
      else
        for (int k = 0; k < NLINK; k++)
          if (int'(lsel[p*LW +: LW]) == k) wd[p] = link_rd[k*DW +: DW];
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    // scan from the highest port down so the lowest port has the last word
    always_comb begin
      nx[r] = rq[r];
      for (int p = NWP - 1; p >= 0; p--)
        if (we[p] && int'(dst[p*RW +: RW]) == r) nx[r] = wd[p];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rq[r] <= '0;
      else        rq[r] <= nx[r];
    end

    assign regs[r*DW +: DW] = rq[r];

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (we == '0) |=> $stable(rq[r])); // R9
  end

  AST_PORT0_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (we[0] && int'(dst[RW-1:0]) < NREG) |=> (rq[$past(dst[RW-1:0])] == $past(wd[0]))); // R6
endmodule

// File: rtl/dpt_outsw.sv
`timescale 1ns/1ps
// Out-switch for one access link: register or FU result onto the link.
module dpt_outsw #(
  parameter int DW   = 8,
  parameter int NREG = 4,
  localparam int MW  = NREG + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                valid,
  input  logic [MW-1:0]       mask,
  input  logic [NREG*DW-1:0]  regs,
  input  logic [DW-1:0]       fu_y,
  output logic [DW-1:0]       wr,
  output logic                oe,
  output logic                conflict
);
  int            cnt;
  logic [DW-1:0] pick;

  always_comb begin
    cnt  = 0;
    pick = '0;
    for (int s = 0; s < NREG; s++)
      if (mask[s]) begin
        cnt  = cnt + 1;
        pick = regs[s*DW +: DW];
      end
    if (mask[NREG]) begin
      cnt  = cnt + 1;
      pick = fu_y;
    end
  end

  assign oe       = valid && (cnt != 0);
  assign conflict = valid && (cnt > 1);
  assign wr       = (oe && !conflict) ? pick : '0;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (wr == '0 && !conflict)); // R7
  AST_CLASH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> (wr == '0 && oe)); // R8
  AST_BLOCKED_NODRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> !oe); // R9
endmodule

// File: rtl/dpt_tile.sv
`timescale 1ns/1ps
// Structured datapath tile: register bank, one FU, in/out switch groups.
module dpt_tile
  import dpt_pkg::*;
#(
  parameter int DW    = 8,
  parameter int NREG  = 4,
  parameter int NLINK = 2,
  parameter int NWP   = 2,
  localparam int RW   = (NREG  > 1) ? $clog2(NREG)  : 1,
  localparam int LW   = (NLINK > 1) ? $clog2(NLINK) : 1,
  localparam int IW   = (RW > LW) ? RW : LW,
  localparam int MW   = NREG + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  step_valid,
  input  logic [2:0]            fu_op,
  input  logic                  opa_from_link,
  input  logic [IW-1:0]         opa_idx,
  input  logic                  opb_from_link,
  input  logic [IW-1:0]         opb_idx,
  input  logic [NWP-1:0]        wr_en,
  input  logic [NWP*RW-1:0]     wr_dst,
  input  logic [NWP-1:0]        wr_from_fu,
  input  logic [NWP*LW-1:0]     wr_link,
  input  logic [NLINK*MW-1:0]   drv_mask,
  input  logic [NLINK*DW-1:0]   link_rd,
  output logic [NLINK*DW-1:0]   link_wr,
  output logic [NLINK-1:0]      link_oe,
  output logic [NLINK-1:0]      link_conflict,
  output logic                  cmp_flag
);
  logic [NREG*DW-1:0] regs;
  logic [DW-1:0]      opa, opb, fu_y;
  logic               fu_flag;
  logic [NWP-1:0]     we_gated;

  dpt_opsel #(.DW(DW), .NREG(NREG), .NLINK(NLINK), .IW(IW)) u_opa (
    .from_link(opa_from_link), .idx(opa_idx), .regs(regs), .links(link_rd), .val(opa));
  dpt_opsel #(.DW(DW), .NREG(NREG), .NLINK(NLINK), .IW(IW)) u_opb (
    .from_link(opb_from_link), .idx(opb_idx), .regs(regs), .links(link_rd), .val(opb));

  dpt_fu #(.DW(DW)) u_fu (.op(fu_op), .a(opa), .b(opb), .y(fu_y), .flag(fu_flag));

  assign cmp_flag = step_valid && fu_flag;
  assign we_gated = wr_en & {NWP{step_valid}};

  dpt_regbank #(.DW(DW), .NREG(NREG), .NLINK(NLINK), .NWP(NWP)) u_rb (
    .clk(clk), .rst_n(rst_n), .we(we_gated), .dst(wr_dst), .from_fu(wr_from_fu),
    .lsel(wr_link), .fu_y(fu_y), .link_rd(link_rd), .regs(regs));

  for (genvar k = 0; k < NLINK; k++) begin : g_link
    dpt_outsw #(.DW(DW), .NREG(NREG)) u_osw (
      .clk(clk), .rst_n(rst_n), .valid(step_valid),
      .mask(drv_mask[k*MW +: MW]), .regs(regs), .fu_y(fu_y),
      .wr(link_wr[k*DW +: DW]), .oe(link_oe[k]), .conflict(link_conflict[k]));
  end

  AST_CMP_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    is_compare(fu_op) |-> (fu_y[DW-1:1] == '0)); // R4
  AST_FLAG_ONLY_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_flag |-> (step_valid && is_compare(fu_op))); // R4
endmodule

// File: tb/dpt_tile_tb.sv
`timescale 1ns/1ps
module dpt_tile_tb;
  localparam int DW = 8, NREG = 4, NLINK = 2, NWP = 2;
  localparam int RW = 2, LW = 1, IW = 2, MW = NREG + 1;

  logic clk = 1'b0, rst_n = 1'b0, step_valid;
  logic [2:0] fu_op;
  logic opa_from_link, opb_from_link;
  logic [IW-1:0] opa_idx, opb_idx;
  logic [NWP-1:0] wr_en, wr_from_fu;
  logic [NWP*RW-1:0] wr_dst;
  logic [NWP*LW-1:0] wr_link;
  logic [NLINK*MW-1:0] drv_mask;
  logic [NLINK*DW-1:0] link_rd, link_wr;
  logic [NLINK-1:0] link_oe, link_conflict;
  logic cmp_flag;

  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dpt_tile #(.DW(DW), .NREG(NREG), .NLINK(NLINK), .NWP(NWP)) u_dut (
    .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .fu_op(fu_op),
    .opa_from_link(opa_from_link), .opa_idx(opa_idx),
    .opb_from_link(opb_from_link), .opb_idx(opb_idx),
    .wr_en(wr_en), .wr_dst(wr_dst), .wr_from_fu(wr_from_fu), .wr_link(wr_link),
    .drv_mask(drv_mask), .link_rd(link_rd), .link_wr(link_wr),
    .link_oe(link_oe), .link_conflict(link_conflict), .cmp_flag(cmp_flag));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model(input int op, input int a, input int b);
    case (op)
      0: return (a + b) & 255;
      1: return (a - b) & 255;
      2: return (a * b) & 255;
      3: return int'(a == b);
      4: return int'(a > b);
      5: return int'(a < b);
      6: return a;
      default: return b;
    endcase
  endfunction

  task automatic idle();
    step_valid = 0; fu_op = 0; opa_from_link = 0; opa_idx = 0;
    opb_from_link = 0; opb_idx = 0; wr_en = 0; wr_dst = 0;
    wr_from_fu = 0; wr_link = 0; drv_mask = 0; link_rd = 0;
  endtask

  task automatic load_reg(input int r, input int v);
    @(negedge clk); idle(); step_valid = 1;
    wr_en = 2'b01; wr_dst[1:0] = r[1:0]; link_rd[7:0] = v[7:0];
    @(posedge clk);
  endtask

  task automatic read_reg(input int r, output int v);
    @(negedge clk); idle(); step_valid = 1;
    drv_mask[MW + r] = 1'b1;
    #5 v = int'(link_wr[15:8]);
  endtask

  initial begin
    #(64'd20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: reset state
    #5 chk(link_oe == 0 && link_conflict == 0 && cmp_flag == 0, "R1 idle outputs",
           int'({link_oe, link_conflict, cmp_flag}), 0);
    for (int r = 0; r < NREG; r++) begin
      read_reg(r, v); chk(v == 0, "R1 reg after reset", v, 0);
    end

    // R3 R4 R11 R2: sweep opcodes and link operands
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 256; a += 17)
        for (int b = 0; b < 256; b += 17) begin
          int e;
          @(negedge clk); idle(); step_valid = 1; fu_op = op[2:0];
          opa_from_link = 1; opa_idx = 0; opb_from_link = 1; opb_idx = 1;
          link_rd = {b[7:0], a[7:0]}; drv_mask[NREG] = 1'b1;
          e = model(op, a, b);
          #5;
          chk(int'(link_wr[7:0]) == e, "R3/R4/R11 fu result", int'(link_wr[7:0]), e);
          chk(int'(cmp_flag) == ((op >= 3 && op <= 5) ? e : 0), "R4 cmp_flag",
              int'(cmp_flag), (op >= 3 && op <= 5) ? e : 0);
        end

    // R2: register operands, all pairs
    for (int r = 0; r < NREG; r++) load_reg(r, 10 + 21 * r);
    for (int i = 0; i < NREG; i++)
      for (int j = 0; j < NREG; j++) begin
        @(negedge clk); idle(); step_valid = 1; fu_op = 3'd1;
        opa_idx = i[1:0]; opb_idx = j[1:0]; drv_mask[NREG] = 1'b1;
        #5 chk(int'(link_wr[7:0]) == (((10 + 21*i) - (10 + 21*j)) & 255),
               "R2 reg operands", int'(link_wr[7:0]), ((10 + 21*i) - (10 + 21*j)) & 255);
      end
    // R2: out-of-range link index gives 0
    @(negedge clk); idle(); step_valid = 1; fu_op = 3'd6;
    opa_from_link = 1; opa_idx = 2'd3; link_rd = 16'hFFFF; drv_mask[NREG] = 1'b1;
    #5 chk(link_wr[7:0] == 0, "R2 index out of range", int'(link_wr[7:0]), 0);

    // R10 R5: FU result to register and link in one step
    @(negedge clk); idle(); step_valid = 1; fu_op = 3'd1;
    opa_from_link = 1; opa_idx = 0; opb_from_link = 1; opb_idx = 1;
    link_rd = {8'd12, 8'd30}; wr_en = 2'b01; wr_from_fu = 2'b01; wr_dst[1:0] = 2'd2;
    drv_mask[NREG] = 1'b1;
    #5 chk(link_wr[7:0] == 18 && link_oe[0], "R10 link side", int'(link_wr[7:0]), 18);
    @(posedge clk);
    read_reg(2, v); chk(v == 18, "R10 register side", v, 18);

    // R6: both ports hit register 3, port 0 wins
    @(negedge clk); idle(); step_valid = 1; link_rd = {8'hA5, 8'h5A};
    wr_en = 2'b11; wr_dst = {2'd3, 2'd3}; wr_link = 2'b10;
    @(posedge clk);
    read_reg(3, v); chk(v == 8'h5A, "R6 lowest port wins", v, 8'h5A);
    // R5: two ports, different targets, both land
    @(negedge clk); idle(); step_valid = 1; link_rd = {8'h33, 8'h44};
    wr_en = 2'b11; wr_dst = {2'd0, 2'd1}; wr_link = 2'b10;
    @(posedge clk);
    read_reg(1, v); chk(v == 8'h44, "R5 port0 write", v, 8'h44);
    read_reg(0, v); chk(v == 8'h33, "R5 port1 write", v, 8'h33);

    // R7: each single source on each link, and empty masks
    // regs now: r0=0x33 r1=0x44 r2=18 r3=0x5A
    for (int k = 0; k < NLINK; k++)
      for (int s = 0; s < MW; s++) begin
        int e;
        case (s) 0: e = 8'h33; 1: e = 8'h44; 2: e = 18; 3: e = 8'h5A; default: e = 77; endcase
        @(negedge clk); idle(); step_valid = 1; fu_op = 3'd6;
        opa_from_link = 1; opa_idx = 0; link_rd[7:0] = 8'd77;
        drv_mask[k*MW + s] = 1'b1;
        #5;
        chk(int'(link_wr[k*8 +: 8]) == e && link_oe[k] && !link_conflict[k],
            "R7 single source", int'(link_wr[k*8 +: 8]), e);
        chk(link_oe[1-k] == 0 && link_wr[(1-k)*8 +: 8] == 0, "R7 empty mask",
            int'(link_oe[1-k]), 0);
      end

    // R8: clash on link 0, link 1 stays clean
    @(negedge clk); idle(); step_valid = 1;
    drv_mask[0] = 1; drv_mask[1] = 1; drv_mask[MW + 2] = 1;
    #5;
    chk(link_conflict[0] && link_oe[0] && link_wr[7:0] == 0, "R8 clash",
        int'(link_wr[7:0]), 0);
    chk(!link_conflict[1] && link_wr[15:8] == 18, "R8 other link", int'(link_wr[15:8]), 18);

    // R9: blocked step
    @(negedge clk); idle(); step_valid = 0; fu_op = 3'd3;
    opa_from_link = 1; opb_from_link = 1; opb_idx = 1; link_rd = 16'h0909;
    wr_en = 2'b11; wr_dst = {2'd2, 2'd0}; wr_link = 2'b00; drv_mask = '1;
    #5 chk(link_oe == 0 && link_conflict == 0 && cmp_flag == 0, "R9 no drive/flag",
           int'({link_oe, link_conflict, cmp_flag}), 0);
    @(posedge clk);
    read_reg(0, v); chk(v == 8'h33, "R9 reg0 unchanged", v, 8'h33);
    read_reg(2, v); chk(v == 18, "R9 reg2 unchanged", v, 18);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule